// File: doc/BRIEF.md
# Bus Traffic Performance Monitor

This block sits beside one port of an on-chip interconnect and measures how much data moves through it. Two single-cycle pulse inputs mark a completed read data beat and a completed write data beat. Four event counters each tally one kind of beat, or both kinds, and a fifth counter tallies clock cycles. Software divides an event count by the cycle count to get port utilisation over a measurement window.

Software drives the block through a simple word-addressed register port. A typical run has four steps. First, select the event type for each counter. Second, switch counters on through the enable-set register. Third, write the control register to clear the counters and start counting in a single write. Fourth, clear the global run bit to freeze every counter at once, then read the values out. Counter 3 is 40 bits wide so that it survives long windows, and it is read as a low word and a high word. All counters wrap to zero silently.

Top module: `bus_perf_monitor`

## Requirements
- R1: After reset the following all read 0: every counter, the enable vector, the control register and every event-select register.
- R2: Enable vector layout: bit n enables event counter n (n = 0..3), and bit 31 enables the cycle counter.
  - A 1 written to offset 0x04 sets the matching bit.
  - A 1 written to offset 0x08 clears the matching bit.
  - A 0 leaves the bit unchanged.
  - Both offsets read back the current vector, and unused bits read 0.
- R3: While the run bit (control bit 0) is 0, no counter changes, whatever its enable bit and the beat inputs.
- R4: The cycle counter (offset 0x0C) adds 1 on every clock edge at which the run bit and enable bit 31 were both set.
- R5: Event-select register n sits at offset 0x24 + 4n. Its bit 0 selects read beats and its bit 1 selects write beats. With both selected, a cycle with both beats adds 2.
- R6: An event counter advances only while its enable bit is set. An enable written in the same cycle as a beat does not count that beat; counting starts on the next cycle.
- R7: Control bit 1 clears all event counters and control bit 2 clears the cycle counter.
  - Both bits are self-clearing and read back 0.
  - The clear takes effect one cycle after the write, so a read straight after the write still shows the old value.
- R8: Counter 3 is 40 bits wide. Offset 0x1C returns bits 31:0, and offset 0x20 returns bits 39:32 in its low 8 bits with the upper bits 0. Counters 0 to 2 read at 0x10, 0x14 and 0x18.
- R9: Reads from unmapped or unaligned offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| rd_beat | input | 1 | Pulse: a read data beat completed |
| wr_beat | input | 1 | Pulse: a write data beat completed |

## Verification
The bench targets the following corner cases:
- **Clear latency.** It reads a counter directly after a clear write and again one cycle later. A design that clears at once, or never, fails one of the two reads.
- **Enable timing.** It sets an enable in the same cycle as a beat. A design that counts that beat reports one too many.
- **Both-beat cycles.** Random beats are run against counters selecting both beat types. A design that adds only 1 when both beats coincide falls short.
- **Enable write semantics.** Zero writes and writes to unused bits go to the set and clear registers. A design that overwrites the vector instead of setting or clearing bits loses enables.
- **Frozen reads.** Beats are driven with the run bit low, and every counter must stay unchanged.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int NUM_EVT    = 4;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 8;
    localparam int CYC_EN_BIT = 31;
    localparam int WIDE_IDX   = NUM_EVT - 1;

    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] A_ENSET  = 8'h04;
    localparam logic [ADDR_W-1:0] A_ENCLR  = 8'h08;
    localparam logic [ADDR_W-1:0] A_CYC    = 8'h0C;
    localparam logic [ADDR_W-1:0] A_EVT    = 8'h10;
    localparam logic [ADDR_W-1:0] A_WIDE_H = A_EVT + ADDR_W'(4 * NUM_EVT);
    localparam logic [ADDR_W-1:0] A_SEL    = A_WIDE_H + 8'h04;

    localparam logic [REG_W-1:0] EN_MASK =
        (REG_W'(1) << CYC_EN_BIT) | ((REG_W'(1) << NUM_EVT) - REG_W'(1));

    typedef enum logic [1:0] {
        EV_OFF = 2'b00,
        EV_RD  = 2'b01,
        EV_WR  = 2'b10,
        EV_RW  = 2'b11
    } evsel_e;

    typedef struct packed {
        logic clr_cyc;
        logic clr_evt;
        logic run;
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] evt_addr(input int n);
        return A_EVT + ADDR_W'(4 * n);
    endfunction

    function automatic logic [ADDR_W-1:0] sel_addr(input int n);
        return A_SEL + ADDR_W'(4 * n);
    endfunction

    function automatic logic [1:0] beat_incr(input evsel_e sel, input logic rd, input logic wr);
        return {1'b0, sel[0] & rd} + {1'b0, sel[1] & wr};
    endfunction

endpackage

// File: rtl/pmu_regs.sv
module pmu_regs
    import pmu_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          we,
    input  logic [REG_W-1:0]              wdata,
    output logic                          run_o,
    output logic                          clr_evt_o,
    output logic                          clr_cyc_o,
    output logic [REG_W-1:0]              en_vec_o,
    output evsel_e [NUM_EVT-1:0]          sel_o
);

    ctrl_t            ctrl_wr;
    logic [REG_W-1:0] wmask;

    assign ctrl_wr = ctrl_t'(wdata[2:0]);
    assign wmask   = wdata & EN_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_o     <= 1'b0;
            clr_evt_o <= 1'b0;
            clr_cyc_o <= 1'b0;
            en_vec_o  <= '0;
            sel_o     <= '{default: EV_OFF};
        end else begin
            clr_evt_o <= 1'b0;
            clr_cyc_o <= 1'b0;
            if (we) begin
                case (addr)
                    A_CTRL: begin
                        run_o     <= ctrl_wr.run;
                        clr_evt_o <= ctrl_wr.clr_evt;
                        clr_cyc_o <= ctrl_wr.clr_cyc;
                    end
                    A_ENSET: en_vec_o <= en_vec_o | wmask;
                    A_ENCLR: en_vec_o <= en_vec_o & ~wmask;
                    default: ;
                endcase
                for (int n = 0; n < NUM_EVT; n++) begin
                    if (addr == sel_addr(n)) sel_o[n] <= evsel_e'(wdata[1:0]);
                end
            end
        end
    end

    // R2: a one written to the set register leaves that bit on
    a_r2_set_sticks: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_ENSET) |=> ((en_vec_o & $past(wmask)) == $past(wmask)));

    // R2: a one written to the clear register leaves that bit off
    a_r2_clr_sticks: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_ENCLR) |=> ((en_vec_o & $past(wmask)) == '0));

    // R7: reset pulses last a single cycle
    a_r7_pulse_once: assert property (@(posedge clk) disable iff (rst)
        (clr_evt_o && !(we && addr == A_CTRL)) |=> !clr_evt_o);

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         cnt_en,
    input  logic [1:0]   incr,
    output logic [W-1:0] value
);

    always_ff @(posedge clk) begin
        if (rst || clr)  value <= '0;
        else if (cnt_en) value <= value + W'(incr);
    end

    // R3: without an enable and without a clear, the value holds
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !clr) |=> $stable(value));

    // R7: a clear pulse zeroes the counter on the next edge
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (value == '0));

    // R5: a counter never advances by more than two per cycle
    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (W'(value - $past(value)) <= W'(2)));

endmodule

// File: rtl/bus_perf_monitor.sv
module bus_perf_monitor
    import pmu_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int WIDE_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rd_beat,
    input  logic              wr_beat
);

    logic                 run, clr_evt, clr_cyc;
    logic [REG_W-1:0]     en_vec;
    evsel_e [NUM_EVT-1:0] sel;
    logic [CNT_W-1:0]     cyc_val;
    logic [WIDE_W-1:0]    evt_val [NUM_EVT];

    pmu_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (reg_addr),
        .we        (reg_we),
        .wdata     (reg_wdata),
        .run_o     (run),
        .clr_evt_o (clr_evt),
        .clr_cyc_o (clr_cyc),
        .en_vec_o  (en_vec),
        .sel_o     (sel)
    );

    pmu_counter #(.W(CNT_W)) u_cyc (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr_cyc),
        .cnt_en (run & en_vec[CYC_EN_BIT]),
        .incr   (2'd1),
        .value  (cyc_val)
    );

    for (genvar n = 0; n < NUM_EVT; n++) begin : g_evt
        localparam int W = (n == WIDE_IDX) ? WIDE_W : CNT_W;
        logic [W-1:0] val;
        pmu_counter #(.W(W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr_evt),
            .cnt_en (run & en_vec[n]),
            .incr   (beat_incr(sel[n], rd_beat, wr_beat)),
            .value  (val)
        );
        assign evt_val[n] = WIDE_W'(val);
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:           reg_rdata = REG_W'(run);
            A_ENSET, A_ENCLR: reg_rdata = en_vec;
            A_CYC:            reg_rdata = REG_W'(cyc_val);
            A_WIDE_H:         reg_rdata = REG_W'(evt_val[WIDE_IDX] >> REG_W);
            default:          reg_rdata = '0;
        endcase
        for (int n = 0; n < NUM_EVT; n++) begin
            if (reg_addr == evt_addr(n)) reg_rdata = evt_val[n][REG_W-1:0];
            if (reg_addr == sel_addr(n)) reg_rdata = REG_W'(sel[n]);
        end
    end

endmodule

// File: tb/tb_bus_perf_monitor.sv
module tb_bus_perf_monitor;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_beat = 1'b0;
    logic        wr_beat = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [39:0] e_evt [4];
    logic [31:0] e_cyc;
    logic [1:0]  e_sel [4];
    logic [3:0]  e_en;

    bus_perf_monitor dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_beat(rd_beat), .wr_beat(wr_beat)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [1:0] inc(logic [1:0] s, logic r, logic w);
        return {1'b0, s[0] & r} + {1'b0, s[1] & w};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic run_rand(int n, bit counting);
        for (int i = 0; i < n; i++) begin
            rd_beat = 1'($urandom % 2);
            wr_beat = 1'($urandom % 2);
            if (counting)
                for (int k = 0; k < 4; k++)
                    if (e_en[k]) e_evt[k] = e_evt[k] + 40'(inc(e_sel[k], rd_beat, wr_beat));
            tick(1);
        end
        rd_beat = 1'b0; wr_beat = 1'b0;
    endtask

    task automatic check_all(string req);
        logic [31:0] d;
        rd(8'h0C, d); chk({req, "/R4 cycle"}, d, e_cyc);
        for (int k = 0; k < 3; k++) begin
            rd(8'(8'h10 + 4 * k), d); chk({req, "/R5 event"}, d, e_evt[k][31:0]);
        end
        rd(8'h1C, d); chk({req, "/R8 wide low"}, d, e_evt[3][31:0]);
        rd(8'h20, d); chk({req, "/R8 wide high"}, d, {24'h0, e_evt[3][39:32]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] r;
        void'($urandom(32'd4242));
        for (int k = 0; k < 4; k++) begin e_evt[k] = '0; e_sel[k] = '0; end
        e_cyc = '0; e_en = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
        rd(8'h04, d); chk("R1 enable", d, 32'h0);
        for (int k = 0; k < 4; k++) begin
            rd(8'(8'h24 + 4 * k), d); chk("R1 select", d, 32'h0);
        end
        check_all("R1");

        // R9 unmapped and unaligned
        rd(8'h34, d); chk("R9 unmapped", d, 32'h0);
        rd(8'hFC, d); chk("R9 unmapped high", d, 32'h0);
        rd(8'h11, d); chk("R9 unaligned", d, 32'h0);

        // R2 set/clear semantics
        wr(8'h04, 32'h8000_0005);
        rd(8'h04, d); chk("R2 set", d, 32'h8000_0005);
        rd(8'h08, d); chk("R2 read via clear", d, 32'h8000_0005);
        wr(8'h08, 32'h0000_0001);
        rd(8'h04, d); chk("R2 clear", d, 32'h8000_0004);
        wr(8'h04, 32'h0);
        wr(8'h04, 32'h7FFF_FFF0);
        rd(8'h04, d); chk("R2 zero/unused bits", d, 32'h8000_0004);

        // R5 select read/write/both, R4 cycles, R8 wide
        e_sel[0] = 2'b01; e_sel[1] = 2'b10; e_sel[2] = 2'b11; e_sel[3] = 2'b11;
        for (int k = 0; k < 4; k++) wr(8'(8'h24 + 4 * k), 32'(e_sel[k]));
        for (int k = 0; k < 4; k++) begin
            rd(8'(8'h24 + 4 * k), d); chk("R5 select readback", d, 32'(e_sel[k]));
        end
        wr(8'h04, 32'h8000_000F); e_en = 4'hF;
        wr(8'h00, 32'h7);
        rd(8'h00, d); chk("R7 reset bits read 0", d, 32'h1);
        tick(1);
        run_rand(200, 1'b1);
        wr(8'h00, 32'h0);
        e_cyc = 32'd201;
        check_all("R5");

        // R3 freeze
        run_rand(50, 1'b0);
        check_all("R3 frozen");

        // R6 disabled counter holds while others count
        wr(8'h08, 32'h2); e_en = 4'hD;
        wr(8'h00, 32'h1);
        tick(1);
        run_rand(100, 1'b1);
        wr(8'h00, 32'h0);
        e_cyc = e_cyc + 32'd102;
        check_all("R6");

        // R7 event clear latency
        wr(8'h00, 32'h2);
        rd(8'h00, d); chk("R7 ctrl reads 0", d, 32'h0);
        rd(8'h10, d); chk("R7 old value before clear", d, e_evt[0][31:0]);
        tick(1);
        for (int k = 0; k < 4; k++) e_evt[k] = '0;
        check_all("R7 event clear");
        wr(8'h00, 32'h4);
        tick(1);
        e_cyc = '0;
        check_all("R7 cycle clear");

        // R6 enable in same cycle as a beat
        wr(8'h00, 32'h1);
        wr_beat = 1'b1;
        wr(8'h04, 32'h2);
        tick(1);
        wr_beat = 1'b0;
        wr(8'h00, 32'h0);
        rd(8'h14, d); chk("R6 enable timing", d, 32'd1);
        rd(8'h18, d); chk("R5 both-select write beats", d, 32'd2);

        // random rounds
        for (int round = 0; round < 5; round++) begin
            wr(8'h00, 32'h6); tick(1);
            for (int k = 0; k < 4; k++) begin
                e_sel[k] = 2'($urandom % 4); e_evt[k] = '0;
                wr(8'(8'h24 + 4 * k), 32'(e_sel[k]));
            end
            r = $urandom;
            e_en = r[3:0];
            wr(8'h08, 32'hFFFF_FFFF);
            wr(8'h04, r | 32'h8000_0000);
            rd(8'h04, d); chk("R2 random enable", d, {1'b1, 27'h0, e_en});
            wr(8'h00, 32'h1);
            tick(1);
            run_rand(300, 1'b1);
            wr(8'h00, 32'h0);
            e_cyc = 32'd302;
            check_all("R5 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule